// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Transmitter

This block is the sending half of the target end of a host-clocked, single-wire debug link. The host opens every bit time by pulling the shared open-drain line low. The target recognises that falling edge through a synchronizer and a low-time filter. It then counts its own clock cycles from the bit start it perceives. For a one it keeps the line released, and for a zero it pulls the line low. In both cases it ends with a one-cycle active-high pulse, so the line does not wait on the slow resistive pull-up.

A byte is handed over with a load strobe and goes out most-significant bit first. The block reports each finished bit and the finished byte. The pin is modelled as three signals: a drive enable, a drive value and the observed pin level.

Top module: `dbg_bit_tx`

## Requirements
- R1: The pin input passes through a two-stage synchronizer. A bit only starts after the synchronized line goes from high to low and then stays low for two consecutive samples. A low lasting one clock is ignored.
- R2: If the pin is first sampled low at rising edge k and is still low at edge k+1, the bit's count-zero cycle begins at edge k+3. Before that cycle the block does not drive the line.
- R3: For a one bit (current data bit = 1), line_oe stays 0 during counts 0 to 6.
- R4: For a zero bit, the block drives low (line_oe=1, line_out=0) during counts 0 to 6. The line is therefore low at count 5, which is where the host samples.
- R5: At count 7 the block drives high (line_oe=1, line_out=1) for exactly one cycle. It releases the line (line_oe=0) at counts 8 and 9.
- R6: bit_done is high for one cycle, during count 9. A falling edge that arrives while a bit sequence is running never starts a second sequence.
- R7: While busy=0, load latches load_data, and busy is 1 from the next cycle. Bits go out most-significant bit first. A load while busy=1 is ignored.
- R8: byte_done is high together with the eighth bit_done. busy is 0 from the following cycle.
- R9: Falling edges while busy=0 start nothing: line_oe and bit_done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that hands over a byte |
| load_data | input | 8 | Byte to send |
| line_in | input | 1 | Observed level of the shared line |
| line_oe | output | 1 | 1 = target drives the line |
| line_out | output | 1 | Level driven when line_oe=1 |
| busy | output | 1 | A byte is loaded and not yet fully sent |
| bit_done | output | 1 | One-cycle pulse at the end of each bit |
| byte_done | output | 1 | One-cycle pulse at the end of the eighth bit |

## Verification
All 256 byte values are sent, so both drive shapes are exercised at every bit position and in every pairing of neighbouring bits. This separates an inverted polarity or a wrong shift direction from a fault that only appears after a particular preceding bit. A one-clock low glitch and a two-clock low tell the edge filter apart from a bare edge detector. A second host low inside a running one bit, a falling edge with nothing loaded, and a load issued mid-byte each show whether the corresponding guard holds or leaks.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;
   localparam int unsigned SYNC_DEPTH_DEF = 2;
   localparam int unsigned LOW_FILT_DEF   = 2;
   localparam int unsigned BOOST_AT_DEF   = 7;
   localparam int unsigned SEQ_LEN_DEF    = 10;
   localparam int unsigned BYTE_W_DEF     = 8;

   typedef struct packed {
      logic oe;
      logic hi;
   } pin_drv_t;
endpackage

// File: rtl/dbgtx_edge.sv
module dbgtx_edge #(
   parameter int unsigned SYNC_DEPTH = 2,
   parameter int unsigned LOW_FILT   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic start_req
);
   localparam int unsigned HW = SYNC_DEPTH + LOW_FILT;
   localparam int unsigned WW = LOW_FILT + 1;

   if (SYNC_DEPTH < 2) begin : g_bad_sync
      $error("SYNC_DEPTH must be at least 2");
   end
   if (LOW_FILT < 1) begin : g_bad_filt
      $error("LOW_FILT must be at least 1");
   end

   logic [HW-1:0] hist;

   // Each stage is its own flop; stage 0 samples the asynchronous pin.
   for (genvar i = 0; i < HW; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hist[i] <= 1'b1;
         else if (i == 0) hist[i] <= line_in;
         else             hist[i] <= hist[i-1];
      end
   end

   // Window: oldest sample high, then LOW_FILT synchronized low samples.
   logic [WW-1:0] window;
   assign window    = hist[HW-1:SYNC_DEPTH-1];
   assign start_req = (window == {1'b1, {LOW_FILT{1'b0}}});

   p_filter_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> !hist[SYNC_DEPTH-1] && $past(!hist[SYNC_DEPTH-2]));
endmodule

// File: rtl/dbgtx_timer.sv
module dbgtx_timer
   import dbgtx_pkg::*;
#(
   parameter int unsigned BOOST_AT = 7,
   parameter int unsigned SEQ_LEN  = 10
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_req,
   input  logic     armed,
   input  logic     bit_val,
   output pin_drv_t drv,
   output logic     seq_active,
   output logic     bit_done
);
   localparam int unsigned CW = $clog2(SEQ_LEN);
   localparam logic [CW-1:0] LAST  = CW'(SEQ_LEN - 1);
   localparam logic [CW-1:0] BOOST = CW'(BOOST_AT);

   if (BOOST_AT + 2 >= SEQ_LEN) begin : g_bad_timing
      $error("BOOST_AT must leave room before the end of the sequence");
   end

   logic [CW-1:0] cnt;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (!active) begin
         if (start_req && armed) begin
            active <= 1'b1;
            cnt    <= '0;
         end
      end else if (cnt == LAST) begin
         active <= 1'b0;
         cnt    <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   logic boost, hold_low;
   assign boost    = active && (cnt == BOOST);
   assign hold_low = active && (cnt < BOOST) && !bit_val;

   assign drv.oe     = boost || hold_low;
   assign drv.hi     = boost;
   assign seq_active = active;
   assign bit_done   = active && (cnt == LAST);

   p_boost_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv.oe && drv.hi) |=> !drv.oe);
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |=> !seq_active);
   p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_active && !bit_done) |=> seq_active && !$stable(cnt));
endmodule

// File: rtl/dbgtx_shifter.sv
module dbgtx_shifter #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              bit_done,
   output logic              busy,
   output logic              cur_bit,
   output logic              byte_done
);
   localparam int unsigned BCW = $clog2(BYTE_W);
   localparam logic [BCW-1:0] LAST_IDX = BCW'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_width
      $error("BYTE_W must be at least 2");
   end

   logic [BYTE_W-1:0] sreg;
   logic [BCW-1:0]    idx;
   logic              full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         idx  <= '0;
         full <= 1'b0;
      end else if (!full) begin
         if (load) begin
            sreg <= load_data;
            idx  <= '0;
            full <= 1'b1;
         end
      end else if (bit_done) begin
         sreg <= {sreg[BYTE_W-2:0], 1'b0};
         idx  <= idx + 1'b1;
         if (idx == LAST_IDX) full <= 1'b0;
      end
   end

   assign busy      = full;
   assign cur_bit   = sreg[BYTE_W-1];
   assign byte_done = full && bit_done && (idx == LAST_IDX);

   p_load_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |=> busy);
   p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_done) |=> $stable(sreg));
   p_byte_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !busy);
endmodule

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx
   import dbgtx_pkg::*;
#(
   parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
   parameter int unsigned LOW_FILT   = LOW_FILT_DEF,
   parameter int unsigned BOOST_AT   = BOOST_AT_DEF,
   parameter int unsigned SEQ_LEN    = SEQ_LEN_DEF,
   parameter int unsigned BYTE_W     = BYTE_W_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              line_in,
   output logic              line_oe,
   output logic              line_out,
   output logic              busy,
   output logic              bit_done,
   output logic              byte_done
);
   logic     start_req;
   logic     cur_bit;
   logic     seq_active;
   pin_drv_t drv;

   dbgtx_edge #(.SYNC_DEPTH(SYNC_DEPTH), .LOW_FILT(LOW_FILT)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_in),
      .start_req (start_req)
   );

   dbgtx_timer #(.BOOST_AT(BOOST_AT), .SEQ_LEN(SEQ_LEN)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .armed      (busy),
      .bit_val    (cur_bit),
      .drv        (drv),
      .seq_active (seq_active),
      .bit_done   (bit_done)
   );

   dbgtx_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (load_data),
      .bit_done  (bit_done),
      .busy      (busy),
      .cur_bit   (cur_bit),
      .byte_done (byte_done)
   );

   assign line_oe  = drv.oe;
   assign line_out = drv.hi;

   p_zero_only_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_oe && !line_out) |-> !cur_bit);
   p_idle_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_active) |-> $past(busy));
   p_done_in_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |-> busy);
endmodule

// File: tb/tb_dbg_bit_tx.sv
module tb_dbg_bit_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load = 1'b0;
   logic [7:0] load_data = '0;
   logic       host_low = 1'b0;
   logic       line_in;
   logic       line_oe, line_out, busy, bit_done, byte_done;
   int         checks = 0;
   int         errors = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   // Open-drain line with pull-up: low if host or target pulls it low.
   assign line_in = ~(host_low | (line_oe & ~line_out));

   dbg_bit_tx dut (
      .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
      .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
      .busy(busy), .bit_done(bit_done), .byte_done(byte_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_load(input logic [7:0] d);
      load = 1'b1;
      load_data = d;
      tick();
      load = 1'b0;
   endtask

   // Called at a negedge; sends one host-clocked bit and checks every cycle.
   task automatic send_bit(input logic b, input logic last, input logic inject);
      host_low = 1'b1;
      tick();
      chk("R2 pre-start oe", int'(line_oe), 0);
      tick();
      chk("R2 pre-start oe", int'(line_oe), 0);
      host_low = 1'b0;
      tick();
      chk("R2 pre-start oe", int'(line_oe), 0);
      for (int j = 0; j < 10; j++) begin
         tick();
         if (j < 7) begin
            if (b) chk("R3 one released", int'(line_oe), 0);
            else   chk("R4 zero driven low", int'({line_oe, line_out}), 2);
         end else if (j == 7) begin
            chk("R5 boost pulse", int'({line_oe, line_out}), 3);
         end else begin
            chk("R5 released after boost", int'(line_oe), 0);
         end
         if (!b && j == 5) chk("R4 line low at host sample", int'(line_in), 0);
         chk("R6 bit_done timing", int'(bit_done), int'(j == 9));
         chk("R8 byte_done timing", int'(byte_done), int'(j == 9 && last));
         if (inject && j == 2) host_low = 1'b1;
         if (inject && j == 4) host_low = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] d);
      for (int i = 7; i >= 0; i--) send_bit(d[i], i == 0, 1'b0);
      tick();
      chk("R8 busy clears", int'(busy), 0);
   endtask

   initial begin
      repeat (3) tick();
      chk("R7 reset busy", int'(busy), 0);
      chk("R5 reset oe", int'(line_oe), 0);
      chk("R6 reset bit_done", int'(bit_done), 0);
      rst_n = 1'b1;
      tick();

      // R9: edge with nothing loaded
      host_low = 1'b1;
      repeat (3) tick();
      host_low = 1'b0;
      for (int i = 0; i < 14; i++) begin
         chk("R9 idle oe", int'(line_oe), 0);
         chk("R9 idle bit_done", int'(bit_done), 0);
         tick();
      end

      // R1: one-cycle glitch while loaded
      do_load(8'hA5);
      chk("R7 busy after load", int'(busy), 1);
      host_low = 1'b1;
      tick();
      host_low = 1'b0;
      for (int i = 0; i < 14; i++) begin
         chk("R1 glitch oe", int'(line_oe), 0);
         chk("R1 glitch bit_done", int'(bit_done), 0);
         tick();
      end

      // R6 second edge mid-bit; R7 load while busy ignored
      send_bit(1'b1, 1'b0, 1'b1);
      send_bit(1'b0, 1'b0, 1'b0);
      do_load(8'h5A);
      send_bit(1'b1, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b1, 1'b0, 1'b0);
      send_bit(1'b0, 1'b0, 1'b0);
      send_bit(1'b1, 1'b1, 1'b0);
      tick();
      chk("R8 busy clears", int'(busy), 0);

      // R7: every byte value, MSB first
      for (int d = 0; d < 256; d++) begin
         do_load(8'(d));
         chk("R7 busy after load", int'(busy), 1);
         send_byte(8'(d));
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule